// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block sits on the host side of a low-power 12-bit successive-approximation converter that has a three-wire serial link: one conversion-start output, one serial clock output and one serial data input. A request from user logic, together with a one-bit select, starts a single conversion. The select picks the converter's second input channel or its bipolar mode. The sequencer tells the converter which one through the pulse pattern on the conversion-start line. With the select low, that line gets one long high pulse. With the select high, it gets a short high pulse, a short low gap and then the long pulse.

While the conversion-start line is high, the converter tracks its input. When the line falls, the converter holds the sample and starts its own conversion. The converter gives no completion signal, so the sequencer waits a fixed worst-case time. It then produces twelve serial clock periods and captures the result most significant bit first. It delivers the word with a one-cycle strobe. It also delivers a widened copy, which is sign-extended when the select was high (two's complement result) and zero-extended otherwise (straight binary). All durations are given in nanoseconds and turned into whole system-clock cycles, always rounded up.

Top module: `serial_adc_seq`

## Requirements
- R1: After reset, and whenever no conversion is in progress, the conversion-start output and the serial clock are low, and busy and the valid strobe are low.
- R2: A request with the select low gives exactly one high pulse on the conversion-start output. The pulse lasts the acquisition time, ACQ_NS rounded up to whole cycles (140 cycles at the defaults).
- R3: A request with the select high gives two high pulses. The first is high for PULSE_NS rounded up (3 cycles). A low gap of the same length follows. Then comes the acquisition pulse of R2.
- R4: The conversion-start output never falls at the end of an acquisition before it has been high for the full acquisition count.
- R5: The first rising serial clock edge comes CONV_NS rounded up (370 cycles) plus one serial half period after the conversion-start output falls. No serial clock edge comes earlier.
- R6: Each conversion produces exactly 12 serial clock pulses. Each high phase and each low phase lasts SCLK_HALF_NS rounded up (7 cycles). The serial clock is low whenever the conversion-start output is high.
- R7: The data input is sampled on each rising serial clock edge. The first bit sampled becomes bit 11 of the result and the last becomes bit 0.
- R8: After the twelfth bit, the valid strobe is high for exactly one cycle with the result. Busy is high from the cycle after an accepted request through the valid cycle and low in the cycle after it.
- R9: A request that arrives while busy is high is ignored. The select that goes with it has no effect on the running conversion, and no further conversion follows.
- R10: The widened output carries the 12-bit result in its low bits. Its upper 4 bits copy result bit 11 when the conversion was requested with the select high, and are zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Conversion request, taken when idle |
| alt_sel_i | input | 1 | 1: second channel or bipolar mode; 0: first channel or unipolar mode |
| cnv_o | output | 1 | Conversion-start line to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idle low |
| sdata_i | input | 1 | Serial data from the converter |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle strobe, result ready |
| result_o | output | 12 | Raw 12-bit result |
| result_ext_o | output | 16 | Widened result, sign- or zero-extended by mode |

## Verification
The hardest case to reach from the ports is a request arriving in the middle of a conversion, with its select set opposite to the one already in use. A faulty design could then restart, emit extra conversion-start pulses or switch the extension mode of the result. The bench starts a bipolar conversion and, during the acquisition window, drives a new request with the select low. It then checks the pulse count, the extension of the delivered word and a quiet period afterwards. A behavioural converter model in the bench follows the conversion-start falls and serial clock falls, and shifts out a chosen word. The boundary words 0x800, 0x7FF, 0xFFF and 0x000 then exercise the sign extension directly.

// File: rtl/serial_adc_seq_pkg.sv
// Package: shared types and the cycle-rounding helper for the ADC sequencer.
// Assumes durations fit in 32 bits after scaling nanoseconds to picoseconds.
package serial_adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_ACQ,
        ST_CONV,
        ST_SHIFT,
        ST_DONE
    } seq_state_e;

    // Whole system-clock cycles covering a duration, rounded up, at least one.
    function automatic int unsigned ns_to_cycles(input int unsigned dur_ns,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (dur_ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/seq_phase_timer.sv
// Module: down-counter that measures the length of one sequencer phase.
// Loading N-1 makes expired_o rise after N cycles in the new phase.
// Assumes the caller loads it on the same edge on which it enters the phase.
module seq_phase_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // A running count only moves down by one (phase lengths are never cut short).
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load_i) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/seq_serial_capture.sv
// Module: generates BITS serial clock pulses and shifts the data input in,
// sampling on each rising serial clock edge, MSB first.
// Assumes the converter changes its data only after a falling serial clock edge.
module seq_serial_capture #(
    parameter int BITS = 12,
    parameter int HALF = 7,
    parameter int HW   = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            sdata_i,
    output logic            sclk_o,
    output logic            done_o,
    output logic [BITS-1:0] word_o
);

    localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [HW-1:0] HALF_LOAD = HW'(HALF - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(BITS - 1);

    logic            active_q;
    logic            sclk_q;
    logic            done_q;
    logic [HW-1:0]   half_q;
    logic [BW-1:0]   bit_q;
    logic [BITS-1:0] shreg_q;

    // Half-period timing, clock toggling, sampling and bit counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sclk_q   <= 1'b0;
            done_q   <= 1'b0;
            half_q   <= '0;
            bit_q    <= '0;
            shreg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
                sclk_q   <= 1'b0;
                half_q   <= HALF_LOAD;
                bit_q    <= '0;
            end else if (active_q) begin
                if (half_q != '0) begin
                    half_q <= half_q - 1'b1;
                end else begin
                    half_q <= HALF_LOAD;
                    if (!sclk_q) begin
                        sclk_q  <= 1'b1;
                        shreg_q <= {shreg_q[BITS-2:0], sdata_i};
                    end else begin
                        sclk_q <= 1'b0;
                        if (bit_q == LAST_BIT) begin
                            active_q <= 1'b0;
                            done_q   <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign done_o = done_q;
    assign word_o = shreg_q;

    // The serial clock only changes once a full half period has elapsed.
    p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_q != $past(sclk_q)) |-> ($past(half_q) == '0 && $past(active_q)));

    // Completion is reported only after the final bit's falling edge.
    p_twelve_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ($past(bit_q) == LAST_BIT && $fell(sclk_q)));

endmodule

// File: rtl/seq_result_format.sv
// Module: widens the raw result, sign-extending for two's complement
// (bipolar) results and zero-extending for straight binary ones.
// Assumes EXT_W is larger than DATA_W.
module seq_result_format #(
    parameter int DATA_W = 12,
    parameter int EXT_W  = 16
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              signed_i,
    output logic [EXT_W-1:0]  ext_o
);

    localparam int PAD_W = EXT_W - DATA_W;

    // Fill the upper bits with the sign bit or with zero, depending on the mode.
    always_comb begin
        ext_o = {{PAD_W{signed_i & word_i[DATA_W-1]}}, word_i};
    end

endmodule

// File: rtl/serial_adc_seq.sv
// Module: top of the ADC conversion sequencer. Takes a request, plays the
// conversion-start pulse pattern, waits out acquisition and conversion,
// reads the 12-bit result serially and presents it with a strobe.
// Assumes one converter per instance and durations given in nanoseconds.
module serial_adc_seq #(
    parameter int SYS_CLK_PS   = 10000,
    parameter int ACQ_NS       = 1400,
    parameter int CONV_NS      = 3700,
    parameter int PULSE_NS     = 30,
    parameter int SCLK_HALF_NS = 63,
    parameter int DATA_W       = 12,
    parameter int EXT_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              alt_sel_i,
    output logic              cnv_o,
    output logic              sclk_o,
    input  logic              sdata_i,
    output logic              busy_o,
    output logic              valid_o,
    output logic [DATA_W-1:0] result_o,
    output logic [EXT_W-1:0]  result_ext_o
);

    import serial_adc_seq_pkg::*;

    localparam int ACQ_CYC   = int'(ns_to_cycles(ACQ_NS, SYS_CLK_PS));
    localparam int CONV_CYC  = int'(ns_to_cycles(CONV_NS, SYS_CLK_PS));
    localparam int PULSE_CYC = int'(ns_to_cycles(PULSE_NS, SYS_CLK_PS));
    localparam int HALF_CYC  = int'(ns_to_cycles(SCLK_HALF_NS, SYS_CLK_PS));
    localparam int MAX_A     = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
    localparam int MAX_CYC   = (MAX_A > PULSE_CYC) ? MAX_A : PULSE_CYC;
    localparam int CW        = $clog2(MAX_CYC + 2);
    localparam int HW        = (HALF_CYC > 1) ? $clog2(HALF_CYC + 1) : 1;

    localparam logic [CW-1:0] ACQ_LOAD   = CW'(ACQ_CYC - 1);
    localparam logic [CW-1:0] CONV_LOAD  = CW'(CONV_CYC - 1);
    localparam logic [CW-1:0] PULSE_LOAD = CW'(PULSE_CYC - 1);

    seq_state_e        state_q, state_d;
    logic              tmr_load;
    logic [CW-1:0]     tmr_val;
    logic              tmr_expired;
    logic              ser_start;
    logic              ser_done;
    logic              ser_sclk;
    logic [DATA_W-1:0] ser_word;
    logic              cnv_q;
    logic              mode_q;
    logic              res_mode_q;
    logic [DATA_W-1:0] res_word_q;
    logic [CW-1:0]     hi_run_q;

    seq_phase_timer #(.W(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    seq_serial_capture #(.BITS(DATA_W), .HALF(HALF_CYC), .HW(HW)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ser_start),
        .sdata_i (sdata_i),
        .sclk_o  (ser_sclk),
        .done_o  (ser_done),
        .word_o  (ser_word)
    );

    seq_result_format #(.DATA_W(DATA_W), .EXT_W(EXT_W)) u_format (
        .word_i   (res_word_q),
        .signed_i (res_mode_q),
        .ext_o    (result_ext_o)
    );

    // Next-state logic and phase-timer loads for the conversion sequence.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        ser_start = 1'b0;
        case (state_q)
            ST_IDLE: if (req_i) begin
                tmr_load = 1'b1;
                if (alt_sel_i) begin
                    state_d = ST_PRE_HI;
                    tmr_val = PULSE_LOAD;
                end else begin
                    state_d = ST_ACQ;
                    tmr_val = ACQ_LOAD;
                end
            end
            ST_PRE_HI: if (tmr_expired) begin
                state_d  = ST_PRE_LO;
                tmr_load = 1'b1;
                tmr_val  = PULSE_LOAD;
            end
            ST_PRE_LO: if (tmr_expired) begin
                state_d  = ST_ACQ;
                tmr_load = 1'b1;
                tmr_val  = ACQ_LOAD;
            end
            ST_ACQ: if (tmr_expired) begin
                state_d  = ST_CONV;
                tmr_load = 1'b1;
                tmr_val  = CONV_LOAD;
            end
            ST_CONV: if (tmr_expired) begin
                state_d   = ST_SHIFT;
                ser_start = 1'b1;
            end
            ST_SHIFT: if (ser_done) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register, registered conversion-start line and request mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnv_q   <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnv_q   <= (state_d == ST_PRE_HI) || (state_d == ST_ACQ);
            if (state_q == ST_IDLE && req_i)
                mode_q <= alt_sel_i;
        end
    end

    // Hold the finished word and its mode until the next result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_word_q <= '0;
            res_mode_q <= 1'b0;
        end else if (ser_done) begin
            res_word_q <= ser_word;
            res_mode_q <= mode_q;
        end
    end

    // Length of the current high run on the conversion-start line (checking aid).
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run_q <= '0;
        else if (!cnv_q)
            hi_run_q <= '0;
        else if (hi_run_q != '1)
            hi_run_q <= hi_run_q + 1'b1;
    end

    assign cnv_o    = cnv_q;
    assign sclk_o   = ser_sclk;
    assign busy_o   = (state_q != ST_IDLE);
    assign valid_o  = (state_q == ST_DONE);
    assign result_o = res_word_q;

    // R4: the acquisition pulse is never shorter than the acquisition count.
    p_acq_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cnv_q) && state_q == ST_CONV) |-> (hi_run_q >= CW'(ACQ_CYC)));

    // R3: the first pulse of the select-high pattern meets the minimum width.
    p_pre_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cnv_q) && state_q == ST_PRE_LO) |-> (hi_run_q >= CW'(PULSE_CYC)));

    // R6: serial clock and conversion-start are never high together.
    p_no_clk_while_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_q |-> !ser_sclk);

    // R8: the valid strobe lasts one cycle and falls with busy.
    p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> (!valid_o && !busy_o));

    // R10: a straight-binary result has no sign fill.
    p_zero_ext_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !res_mode_q) |-> (result_ext_o[EXT_W-1:DATA_W] == '0));

endmodule

// File: tb/serial_adc_seq_tb_top.sv
module serial_adc_seq_tb_top;

    localparam int CLK_PS  = 10000;
    localparam int ACQ_E   = (1400 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int CONV_E  = (3700 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int PULSE_E = (30 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int HALF_E  = (63 * 1000 + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        alt_sel = 1'b0;
    logic        sdata = 1'b0;
    logic        cnv, sclk, busy, valid;
    logic [11:0] result;
    logic [15:0] result_ext;

    int checks = 0;
    int fails  = 0;

    // converter model and line monitor state
    logic [11:0] adc_word = '0;
    int cyc = 0;
    int cnv_rises = 0, valid_cnt = 0;
    int rise_prev = 0, rise_last = 0, fall_prev = 0, fall_last = 0;
    int sclk_cnt = 0, sclk_first = 0, sclk_rise_t = 0, sclk_fall_t = 0;
    int hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
    int bit_idx = 0;
    logic cnv_prev = 1'b0, sclk_prev = 1'b0;

    always #5ns clk = ~clk;

    serial_adc_seq dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .alt_sel_i    (alt_sel),
        .cnv_o        (cnv),
        .sclk_o       (sclk),
        .sdata_i      (sdata),
        .busy_o       (busy),
        .valid_o      (valid),
        .result_o     (result),
        .result_ext_o (result_ext)
    );

    // Monitor the lines away from the clock edge and play the converter's part.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (valid) valid_cnt = valid_cnt + 1;
        if (cnv && !cnv_prev) begin
            cnv_rises = cnv_rises + 1;
            rise_prev = rise_last; rise_last = cyc;
            sclk_cnt = 0; hi_min = 1 << 20; hi_max = 0; lo_min = 1 << 20; lo_max = 0;
        end
        if (!cnv && cnv_prev) begin
            fall_prev = fall_last; fall_last = cyc;
            bit_idx = 11; sdata = adc_word[11];
        end
        if (sclk && !sclk_prev) begin
            if (sclk_cnt == 0) sclk_first = cyc;
            else begin
                if (cyc - sclk_fall_t < lo_min) lo_min = cyc - sclk_fall_t;
                if (cyc - sclk_fall_t > lo_max) lo_max = cyc - sclk_fall_t;
            end
            sclk_cnt = sclk_cnt + 1; sclk_rise_t = cyc;
        end
        if (!sclk && sclk_prev) begin
            sclk_fall_t = cyc;
            if (cyc - sclk_rise_t < hi_min) hi_min = cyc - sclk_rise_t;
            if (cyc - sclk_rise_t > hi_max) hi_max = cyc - sclk_rise_t;
            if (bit_idx > 0) begin bit_idx = bit_idx - 1; sdata = adc_word[bit_idx]; end
        end
        cnv_prev = cnv; sclk_prev = sclk;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     rq, what, act, act, exp, exp);
        end
    endtask

    task automatic issue(input bit sel);
        @(negedge clk); req = 1'b1; alt_sel = sel;
        @(negedge clk); req = 1'b0; alt_sel = 1'b0;
    endtask

    // Wait for the strobe, then check the word, its extension and the line timing.
    task automatic finish_conv(input bit sel, input logic [11:0] w, input int rises0,
                               input int valid0);
        int n = 0;
        logic [15:0] exp_ext;
        while (!valid && n < 5000) begin @(negedge clk); n++; end
        chk(valid, "R8", "valid seen", int'(valid), 1);
        chk(busy, "R8", "busy during valid", int'(busy), 1);
        chk(result == w, "R7", "result word", int'(result), int'(w));
        exp_ext = sel ? {{4{w[11]}}, w} : {4'h0, w};
        chk(result_ext == exp_ext, "R10", "extended word", int'(result_ext), int'(exp_ext));
        @(negedge clk);
        chk(!valid && !busy, "R8", "strobe one cycle, busy dropped",
            int'({valid, busy}), 0);
        chk(valid_cnt - valid0 == 1, "R8", "single strobe", valid_cnt - valid0, 1);
        if (sel) begin
            chk(cnv_rises - rises0 == 2, "R3", "conversion-start pulses", cnv_rises - rises0, 2);
            chk(fall_prev - rise_prev == PULSE_E, "R3", "first pulse width",
                fall_prev - rise_prev, PULSE_E);
            chk(rise_last - fall_prev == PULSE_E, "R3", "gap width",
                rise_last - fall_prev, PULSE_E);
        end else begin
            chk(cnv_rises - rises0 == 1, "R2", "conversion-start pulses", cnv_rises - rises0, 1);
        end
        chk(fall_last - rise_last == ACQ_E, "R2", "acquisition width",
            fall_last - rise_last, ACQ_E);
        chk(sclk_first - fall_last == CONV_E + HALF_E, "R5", "first serial edge delay",
            sclk_first - fall_last, CONV_E + HALF_E);
        chk(sclk_cnt == 12, "R6", "serial clock pulses", sclk_cnt, 12);
        chk(hi_min == HALF_E && hi_max == HALF_E, "R6", "high phase", hi_max, HALF_E);
        chk(lo_min == HALF_E && lo_max == HALF_E, "R6", "low phase", lo_max, HALF_E);
        chk(!cnv && !sclk, "R1", "lines idle after conversion", int'({cnv, sclk}), 0);
    endtask

    task automatic t_reset();
        chk(!cnv, "R1", "cnv at reset", int'(cnv), 0);
        chk(!sclk, "R1", "sclk at reset", int'(sclk), 0);
        chk(!busy, "R1", "busy at reset", int'(busy), 0);
        chk(!valid, "R1", "valid at reset", int'(valid), 0);
    endtask

    task automatic t_convert(input bit sel, input logic [11:0] w);
        int r0 = cnv_rises;
        int v0 = valid_cnt;
        adc_word = w;
        issue(sel);
        chk(busy, "R8", "busy after request", int'(busy), 1);
        finish_conv(sel, w, r0, v0);
    endtask

    // R9: a second request with the opposite select during acquisition is dropped.
    task automatic t_busy_ignored();
        int r0 = cnv_rises;
        int v0 = valid_cnt;
        int r1;
        adc_word = 12'h9AB;
        issue(1'b1);
        repeat (20) @(negedge clk);
        req = 1'b1; alt_sel = 1'b0;
        @(negedge clk); req = 1'b0;
        finish_conv(1'b1, 12'h9AB, r0, v0);
        r1 = cnv_rises;
        repeat (200) @(negedge clk);
        chk(cnv_rises == r1 && !busy, "R9", "no conversion after ignored request",
            cnv_rises - r1, 0);
    endtask

    initial begin
        #5ms;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_convert(1'b0, 12'hA5C);
        t_convert(1'b1, 12'h800);
        t_convert(1'b1, 12'h7FF);
        t_convert(1'b0, 12'hFFF);
        t_convert(1'b1, 12'h000);
        t_busy_ignored();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule